// File: doc/BRIEF.md
# Single-Word MDIO Management Controller

This block lets a host run a complete clause-22 PHY management transaction through one 32-bit control word. The host writes the packed word (operation, PHY address, register address, write data) and the block serialises a full management frame on the MDC/MDIO pair. The MDC clock is derived from the system clock by a parameterised divider. During a read, the block releases MDIO at the turnaround and captures the PHY's sixteen data bits.

The same word is read back as a status register. A ready flag drops when a command is accepted and returns when the frame has finished. On a read the low half then carries the returned data. A sticky completion flag also rises and stays set until the host clears it.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset `ctrl_rdata` reads 32'h1000_0000 (bit 28 ready = 1, all other bits 0), and `mdc`, `mdio_oe` and `irq_done` are 0.
- R2: The command word is laid out as follows: bits [27:26] are the opcode (01 = write, 10 = read), bits [25:21] the PHY address, bits [20:16] the register address and bits [15:0] the write data. A `cmd_wr` pulse that arrives while ready = 1 with a valid opcode is accepted. On the next cycle `ctrl_rdata` shows ready = 0, data = 0, and opcode and addresses equal to the command.
- R3: A command with opcode 00 or 11 is ignored: `ctrl_rdata` is unchanged and no MDC edge and no frame follow.
- R4: A `cmd_wr` pulse while ready = 0 is ignored: the opcode and address fields keep the running command, and only one frame (the running one) goes out.
- R5: Each frame is sent MSB first on MDC rising edges, in this order: 32 ones, start bits 0 then 1, 2-bit opcode, 5-bit PHY address, 5-bit register address, 2 turnaround bits, then 16 data bits. On a write the block drives the turnaround as 1, 0.
- R6: On a read, `mdio_oe` is 0 from the first turnaround bit through the last data bit. `mdio_i` is sampled at the 16 data-bit MDC rising edges, MSB first, and the result is returned in `ctrl_rdata[15:0]`.
- R7: While a frame runs, MDC has a period of 2*MDC_HALF system clocks. MDC is 0 while ready = 1. `mdio_o` and `mdio_oe` never change in a cycle where MDC is high.
- R8: At the end of a frame, ready returns to 1. The data field then holds the captured read data (read) or the written data (write), and `irq_done` is set in that same cycle.
- R9: `irq_done` stays set until an `irq_clr` pulse clears it. Accepting a new command does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Host write strobe for the control word |
| cmd_wdata | input | 32 | Packed command word |
| irq_clr | input | 1 | Write-one-to-clear pulse for the completion flag |
| mdio_i | input | 1 | Resolved MDIO line value |
| ctrl_rdata | output | 32 | Control/status word readback |
| irq_done | output | 1 | Sticky management-cycle-done flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |

## Verification
The assertions check the following on every cycle: MDIO output and enable hold steady while MDC is high, and the bus stays quiet when idle. They also check the register image right after an accepted command, that the command fields are frozen while busy, that invalid opcodes leave the word untouched, and that the completion flag rises only together with ready and falls only after a clear. The bench's PHY responder is needed to show the bit order of whole frames, the turnaround release, the returned read data, the measured MDC period, and that a command written while busy produces no second frame.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;   // first turnaround bit
    localparam int DATA_POS   = 48;   // first data bit
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_BAD   = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic [3:0]  rsvd;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdio_cmd_t;

    function automatic logic op_is_valid(input logic [1:0] op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

    // Whole frame, MSB goes out first.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]  ta;
        logic [15:0] dat;
        ta  = (c.op == OP_READ) ? 2'b11 : 2'b10;
        dat = (c.op == OP_READ) ? 16'hFFFF : c.data;
        return {32'hFFFF_FFFF, 2'b01, c.op, c.phy, c.regad, ta, dat};
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int HALF_CYCLES = 4   // system clocks per MDC half period (min 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_stb,
    output logic drive_stb
);
    localparam int EFF_HALF = (HALF_CYCLES < 2) ? 2 : HALF_CYCLES;
    localparam int CW       = $clog2(EFF_HALF);
    localparam logic [CW-1:0] LAST = CW'(EFF_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          clk_lvl;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d     = div_q;
        rise_stb  = 1'b0;
        drive_stb = 1'b0;
        if (!en) begin
            div_d = '0;
        end else begin
            rise_stb  = (div_q.cnt == LAST) && !div_q.clk_lvl;
            drive_stb = (div_q.cnt == '0) && !div_q.clk_lvl;
            if (div_q.cnt == LAST) begin
                div_d.cnt     = '0;
                div_d.clk_lvl = ~div_q.clk_lvl;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc = div_q.clk_lvl;
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] start_frame,
    input  logic                  start_rd,
    input  logic                  rise_stb,
    input  logic                  drive_stb,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  done,
    output logic [15:0]           rdata,
    output logic                  mdio_o,
    output logic                  mdio_oe
);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(FRAME_BITS);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] IDX_SAMP = IDX_W'(DATA_POS + 1);

    typedef struct packed {
        logic                  busy;
        logic                  is_rd;
        logic [FRAME_BITS-1:0] sh;
        logic [IDX_W-1:0]      idx;    // bits already placed on the line
        logic [15:0]           rd;
        logic                  mdo;
        logic                  oe;
        logic                  done;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (start && !eng_q.busy) begin
            eng_d.busy  = 1'b1;
            eng_d.is_rd = start_rd;
            eng_d.sh    = start_frame;
            eng_d.idx   = '0;
            eng_d.rd    = '0;
            eng_d.mdo   = 1'b0;
            eng_d.oe    = 1'b0;
        end else if (eng_q.busy) begin
            if (drive_stb) begin
                if (eng_q.idx == IDX_END) begin
                    eng_d.busy = 1'b0;
                    eng_d.oe   = 1'b0;
                    eng_d.mdo  = 1'b0;
                    eng_d.done = 1'b1;
                end else begin
                    eng_d.mdo = eng_q.sh[FRAME_BITS-1];
                    eng_d.sh  = {eng_q.sh[FRAME_BITS-2:0], 1'b0};
                    eng_d.oe  = !(eng_q.is_rd && (eng_q.idx >= IDX_TA));
                    eng_d.idx = eng_q.idx + 1'b1;
                end
            end
            if (rise_stb && eng_q.is_rd && (eng_q.idx >= IDX_SAMP)) begin
                eng_d.rd = {eng_q.rd[14:0], mdio_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy    = eng_q.busy;
    assign done    = eng_q.done;
    assign rdata   = eng_q.rd;
    assign mdio_o  = eng_q.mdo;
    assign mdio_oe = eng_q.oe;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    input  logic        irq_clr,
    input  logic        mdio_i,
    output logic [31:0] ctrl_rdata,
    output logic        irq_done,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    typedef struct packed {
        logic        ready;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
        logic [15:0] wr_hold;
        logic        irq;
    } reg_t;

    localparam reg_t REG_RST = '{ready: 1'b1, default: '0};

    reg_t      reg_d, reg_q;
    mdio_cmd_t cmd;
    logic      accept;
    logic      eng_busy, eng_done;
    logic      rise_stb, drive_stb;
    logic [15:0] eng_rdata;
    logic [3:0]  unused_rsvd;

    assign cmd         = mdio_cmd_t'(cmd_wdata);
    assign unused_rsvd = cmd.rsvd;
    assign accept      = cmd_wr && reg_q.ready && op_is_valid(cmd.op);

    always_comb begin
        reg_d = reg_q;
        if (accept) begin
            reg_d.ready   = 1'b0;
            reg_d.op      = cmd.op;
            reg_d.phy     = cmd.phy;
            reg_d.regad   = cmd.regad;
            reg_d.data    = '0;
            reg_d.wr_hold = cmd.data;
        end
        if (eng_done) begin
            reg_d.ready = 1'b1;
            reg_d.data  = (reg_q.op == OP_READ) ? eng_rdata : reg_q.wr_hold;
        end
        if (irq_clr)  reg_d.irq = 1'b0;
        if (eng_done) reg_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= REG_RST;
        else        reg_q <= reg_d;
    end

    mdio_mdc_gen #(.HALF_CYCLES(MDC_HALF)) u_mdc_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (eng_busy),
        .mdc       (mdc),
        .rise_stb  (rise_stb),
        .drive_stb (drive_stb)
    );

    mdio_frame_eng u_frame_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_frame (build_frame(cmd)),
        .start_rd    (cmd.op == OP_READ),
        .rise_stb    (rise_stb),
        .drive_stb   (drive_stb),
        .mdio_i      (mdio_i),
        .busy        (eng_busy),
        .done        (eng_done),
        .rdata       (eng_rdata),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe)
    );

    assign ctrl_rdata = {3'b000, reg_q.ready, reg_q.op, reg_q.phy, reg_q.regad, reg_q.data};
    assign irq_done   = reg_q.irq;
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [31:0] cmd_wdata,
    input logic        irq_clr,
    input logic [31:0] ctrl_rdata,
    input logic        irq_done,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic ready;
    logic valid_op;
    assign ready    = ctrl_rdata[28];
    assign valid_op = (cmd_wdata[27:26] == 2'b01) || (cmd_wdata[27:26] == 2'b10);

    // R7
    mdio_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!mdc && !mdio_oe));

    // R2
    accept_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && ready && valid_op) |=>
            (!ctrl_rdata[28] && ctrl_rdata[15:0] == 16'h0000 &&
             ctrl_rdata[27:16] == $past(cmd_wdata[27:16])));

    // R3
    bad_op_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && ready && !valid_op) |=> $stable(ctrl_rdata));

    // R4
    busy_fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(ctrl_rdata[27:16]));

    // R8
    irq_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_done) |-> $rose(ready));

    // R9
    irq_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_done) |-> $past(irq_clr));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_wdata  (cmd_wdata),
    .irq_clr    (irq_clr),
    .ctrl_rdata (ctrl_rdata),
    .irq_done   (irq_done),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
);

// File: tb/test_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module test_mdio_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MDC_HALF   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        irq_clr = 1'b0;
    logic [31:0] ctrl_rdata;
    logic        irq_done, mdc, mdio_o, mdio_oe;
    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;
    logic        mdio_line;

    int checks = 0;
    int fails  = 0;

    // responder state
    int          fpos = 0;
    int          ones = 0;
    int          frames = 0;
    logic [29:0] acc = '0;
    logic [29:0] last_acc = '0;
    logic [1:0]  seen_op = '0;
    logic [15:0] phy_word = '0;
    bit          oe_clash = 1'b0;
    time         t_prev = 0;
    time         t_last = 0;

    // scenario variables
    int          seed_dummy;
    int          f_save;
    time         t_save;
    logic [31:0] snap;
    bit          ok_flag;
    bit          mdc_seen;

    assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_cmd_ctrl #(.MDC_HALF(MDC_HALF)) i_mdio_cmd_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_wdata  (cmd_wdata),
        .irq_clr    (irq_clr),
        .mdio_i     (mdio_line),
        .ctrl_rdata (ctrl_rdata),
        .irq_done   (irq_done),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    function automatic logic [15:0] rd_model(input logic [4:0] phy, input logic [4:0] rg);
        return {phy, rg, 6'h15} ^ 16'h3C96;
    endfunction

    // PHY responder: decodes frames on MDC rising edges, answers reads
    always @(posedge mdc) begin
        t_prev = t_last;
        t_last = $time;
        if (fpos == 0) begin
            if (mdio_line) ones++;
            else begin
                if (ones >= 32) fpos = 33;
                ones = 0;
            end
        end else if (fpos == 33) begin
            fpos = mdio_line ? 34 : 0;
        end else begin
            acc = {acc[28:0], mdio_line};
            if (fpos == 35) seen_op = acc[1:0];
            if (fpos == 45) phy_word = rd_model(acc[9:5], acc[4:0]);
            if (seen_op == 2'b10 && fpos >= 46 && mdio_oe) oe_clash = 1'b1;
            if (seen_op == 2'b10) begin
                if (fpos == 46) begin
                    phy_en  <= 1'b1;
                    phy_val <= 1'b0;
                end else if (fpos >= 47 && fpos <= 62) begin
                    phy_val <= phy_word[62 - fpos];
                end else if (fpos == 63) begin
                    phy_en <= 1'b0;
                end
            end
            if (fpos == 63) begin
                frames++;
                last_acc = acc;
                fpos = 0;
                ones = 0;
            end else begin
                fpos++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_ready(output bit ok);
        int n = 0;
        while (!ctrl_rdata[28] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        ok = ctrl_rdata[28];
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] dat, input bit clear_irq);
        int          f0;
        bit          ok;
        bit          irq_before;
        logic [15:0] exp_d;
        f0 = frames;
        @(negedge clk);
        irq_before = irq_done;
        cmd_wdata  = {4'b0000, op, phy, rg, dat};
        cmd_wr     = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(ctrl_rdata == {4'b0000, op, phy, rg, 16'h0000}, "R2 accepted image",
            ctrl_rdata, {4'b0000, op, phy, rg, 16'h0000});
        chk(irq_done == irq_before, "R9 flag kept over accept", 32'(irq_done), 32'(irq_before));
        wait_ready(ok);
        chk(ok, "R8 ready returns", 32'(ok), 32'd1);
        exp_d = (op == 2'b10) ? rd_model(phy, rg) : dat;
        chk(ctrl_rdata == {3'b000, 1'b1, op, phy, rg, exp_d},
            (op == 2'b10) ? "R6 read data returned" : "R8 write data returned",
            ctrl_rdata, {3'b000, 1'b1, op, phy, rg, exp_d});
        chk(irq_done, "R8 done flag set", 32'(irq_done), 32'd1);
        chk(frames == f0 + 1, "R5 one frame sent", 32'(frames), 32'(f0 + 1));
        chk(last_acc == {op, phy, rg, 2'b10, exp_d}, "R5 frame bit order",
            32'(last_acc), 32'({op, phy, rg, 2'b10, exp_d}));
        if (op == 2'b10) begin
            chk(!oe_clash, "R6 released from turnaround", 32'(oe_clash), 32'd0);
            oe_clash = 1'b0;
        end
        if (clear_irq) begin
            @(negedge clk);
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            chk(!irq_done, "R9 cleared by pulse", 32'(irq_done), 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL R8 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        chk(ctrl_rdata == 32'h1000_0000, "R1 word in reset", ctrl_rdata, 32'h1000_0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_rdata == 32'h1000_0000, "R1 word after reset", ctrl_rdata, 32'h1000_0000);
        chk({mdc, mdio_oe, irq_done} == 3'b000, "R1 pins after reset",
            32'({mdc, mdio_oe, irq_done}), 32'd0);

        // directed corners
        run_cmd(2'b01, 5'd0,  5'd0,  16'h0000, 1'b1);
        run_cmd(2'b01, 5'd31, 5'd31, 16'hFFFF, 1'b1);
        run_cmd(2'b10, 5'd31, 5'd31, 16'h0000, 1'b1);
        run_cmd(2'b10, 5'd0,  5'd0,  16'h1234, 1'b1);
        run_cmd(2'b01, 5'd17, 5'd2,  16'h8001, 1'b1);

        // R7: MDC period and idle level
        chk(t_last - t_prev == time'(2 * MDC_HALF * CLK_PERIOD), "R7 MDC period",
            32'(t_last - t_prev), 32'(2 * MDC_HALF * CLK_PERIOD));
        mdc_seen = 1'b0;
        repeat (4 * MDC_HALF) begin
            @(negedge clk);
            if (mdc) mdc_seen = 1'b1;
        end
        chk(!mdc_seen, "R7 MDC low while idle", 32'(mdc_seen), 32'd0);

        // R3: invalid opcodes
        snap   = ctrl_rdata;
        f_save = frames;
        t_save = t_last;
        @(negedge clk);
        cmd_wdata = {4'b0000, 2'b00, 5'd3, 5'd4, 16'hBEEF};
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(ctrl_rdata == snap, "R3 opcode 00 ignored", ctrl_rdata, snap);
        cmd_wdata = {4'b0000, 2'b11, 5'd6, 5'd7, 16'hCAFE};
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(ctrl_rdata == snap, "R3 opcode 11 ignored", ctrl_rdata, snap);
        repeat (8 * MDC_HALF) @(negedge clk);
        chk(t_last == t_save && frames == f_save, "R3 no MDC activity",
            32'(frames), 32'(f_save));

        // R4: write while busy
        f_save = frames;
        @(negedge clk);
        cmd_wdata = {4'b0000, 2'b01, 5'd9, 5'd12, 16'h5AA5};
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (20) @(negedge clk);
        cmd_wdata = {4'b0000, 2'b10, 5'd1, 5'd1, 16'h0F0F};
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(ctrl_rdata[28:16] == {1'b0, 2'b01, 5'd9, 5'd12}, "R4 busy write ignored",
            32'(ctrl_rdata[28:16]), 32'({1'b0, 2'b01, 5'd9, 5'd12}));
        wait_ready(ok_flag);
        chk(ctrl_rdata == {4'b0001, 2'b01, 5'd9, 5'd12, 16'h5AA5}, "R4 first command kept",
            ctrl_rdata, {4'b0001, 2'b01, 5'd9, 5'd12, 16'h5AA5});
        repeat (8 * MDC_HALF) @(negedge clk);
        chk(frames == f_save + 1, "R4 single frame", 32'(frames), 32'(f_save + 1));
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;

        // R9: flag left set across a following command
        run_cmd(2'b10, 5'd5, 5'd9, 16'h0000, 1'b0);
        run_cmd(2'b01, 5'd6, 5'd10, 16'h7E81, 1'b1);

        // constrained random traffic
        for (int k = 0; k < 30; k++) begin
            logic [1:0] rop;
            rop = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
            run_cmd(rop, 5'($urandom), 5'($urandom), 16'($urandom), ($urandom % 3) != 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule